// File: doc/BRIEF.md
# Self-Calibrating Millisecond Tick Counter

This block produces a tick count that advances at roughly 1 kHz. Its time base is a slow clock whose frequency is only loosely known, anywhere from about 22 kHz to 40 kHz. On request, the block measures the slow clock against the fast reference clock, which is also the block's system clock. It then computes a rounded prescaler divider from that measurement. Finally it restarts a slow-clock prescaler whose wraps advance the tick count.

A calibration starts with a one-cycle `start_i` pulse. The slow clock is synchronised into the fast domain, and only its rising edges are used. The measurement counts fast cycles across `PERIODS` (16) slow periods. With a nominal 16 MHz reference, that count equals 16 × f_fast / f_slow. The divider is `(NUMER + m/2) / m` in integer arithmetic with `NUMER` = 256000, so it is rounded to the nearest whole value. A division runs one quotient bit per cycle.

If the measurement or the quotient is zero, the old divider stays in force and an error flag is raised. Rounding the divider bounds the tick-rate error to a few percent across the whole slow-clock range. The count can be read at any time through a read strobe without disturbing it.

Top module: `tick_cal_counter`

## Requirements
- R1: After reset, `ticks_o`, `rd_data_o` and `cal_err_o` are 0. `ticks_o` stays 0 until the first successful calibration, whatever the slow clock does.
- R2: A calibration measures m = the number of fast cycles spanned by `PERIODS` consecutive slow-clock rising periods, taken modulo 2^`MEAS_W`. The window opens at the first slow rising edge after `start_i`.
- R3: The divider loaded is floor((`NUMER` + floor(m/2)) / m).
- R4: Loading a new divider forces both the prescaler and `ticks_o` to 0.
- R5: The prescaler counts slow rising edges from 0 to divider−1. `ticks_o` grows by one each time the prescaler returns to 0, so with a steady slow period P, successive ticks are exactly divider × P fast cycles apart.
- R6: A measurement of 0, or a quotient of 0, keeps the previous divider and leaves counting untouched, and sets `cal_err_o` to 1. The next successful load clears `cal_err_o`.
- R7: `ticks_o` wraps modulo 2^`CNT_W`, going from all ones to 0.
- R8: A cycle with `rd_i` high copies the `ticks_o` value of that cycle into `rd_data_o` in the next cycle, and the tick count keeps advancing unchanged.
- R9: A `start_i` pulse while counting recalibrates. Counting continues at the old rate until the new divider loads, and after that it runs at the new rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock, also the system clock |
| rst_i | input | 1 | Synchronous active-high reset |
| slow_clk_i | input | 1 | Slow time-base clock, asynchronous to clk_i |
| start_i | input | 1 | One-cycle pulse that starts a calibration |
| rd_i | input | 1 | Read strobe that captures the tick count |
| ticks_o | output | CNT_W | Free-running tick count |
| rd_data_o | output | CNT_W | Tick count captured on the last read strobe |
| cal_err_o | output | 1 | Last calibration was rejected (zero measurement or quotient) |

## Verification
The assertions assume that `slow_clk_i` is much slower than `clk_i`, so every slow edge yields exactly one synchronised rising pulse. The stimulus generates the slow clock from the fast clock, with periods of 20 to 64 fast cycles. The assertions also assume that `start_i` is a short pulse. The bench applies each new slow period only after several full periods have passed at the new value, so each measurement window sees a steady period. A period of 64 with a 10-bit measurement makes the measured value wrap to exactly zero, which exercises the rejection path.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE = 2'd0,
    CAL_MEAS = 2'd1,
    CAL_DIV  = 2'd2
  } cal_state_e;
endpackage

// File: rtl/tick_edge_sync.sv
module tick_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic rise_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q;
  logic         prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[TOP-1:0], async_i};
      prev_q <= sync_q[TOP];
      rise_o <= sync_q[TOP] & ~prev_q;
    end
  end

  // A synchronised rising edge is a single-cycle pulse
  AST_RISE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_o |=> !rise_o); // R5
endmodule

// File: rtl/tick_period_meas.sv
module tick_period_meas #(
  parameter int MEAS_W  = 16,
  parameter int PERIODS = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic              edge_i,
  output logic              done_o,
  output logic [MEAS_W-1:0] value_o
);
  localparam int PW = $clog2(PERIODS + 1);
  localparam logic [PW-1:0] LAST_EDGE = PW'(PERIODS - 1);

  logic              armed_q;
  logic              active_q;
  logic [PW-1:0]     edges_q;
  logic [MEAS_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      armed_q  <= 1'b0;
      active_q <= 1'b0;
      edges_q  <= '0;
      cnt_q    <= '0;
      done_o   <= 1'b0;
      value_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        armed_q  <= 1'b1;
        active_q <= 1'b0;
      end else if (armed_q && edge_i) begin
        armed_q  <= 1'b0;
        active_q <= 1'b1;
        cnt_q    <= '0;
        edges_q  <= '0;
      end else if (active_q) begin
        if (edge_i && edges_q == LAST_EDGE) begin
          active_q <= 1'b0;
          done_o   <= 1'b1;
          value_o  <= cnt_q + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (edge_i) edges_q <= edges_q + 1'b1;
        end
      end
    end
  end

  AST_MEAS_DONE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o); // R2
  AST_MEAS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (rst_i)
    !(armed_q && active_q)); // R2
endmodule

// File: rtl/tick_seq_div.sv
module tick_seq_div #(
  parameter int DVD_W = 19,
  parameter int DVS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             done_o,
  output logic [DVD_W-1:0] quot_o
);
  localparam int SW = $clog2(DVD_W + 1);

  logic [DVS_W-1:0] rem_q;
  logic [DVS_W-1:0] dvs_q;
  logic [SW-1:0]    step_q;
  logic             busy_q;
  logic [DVS_W:0]   trial;
  logic             fits;

  always_comb begin
    trial = {rem_q, quot_o[DVD_W-1]};
    fits  = (trial >= {1'b0, dvs_q});
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
      quot_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        quot_o <= dividend_i;
        dvs_q  <= divisor_i;
        rem_q  <= '0;
        step_q <= SW'(DVD_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= fits ? DVS_W'(trial - {1'b0, dvs_q}) : trial[DVS_W-1:0];
        quot_o <= {quot_o[DVD_W-2:0], fits};
        step_q <= step_q - 1'b1;
        if (step_q == SW'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  // Partial remainder never reaches the divisor
  AST_REM_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_q && dvs_q != '0) |-> (rem_q < dvs_q)); // R3
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV_W = 19,
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             edge_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic             run_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] pre_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q <= 1'b0;
      div_q <= '0;
      pre_q <= '0;
      cnt_o <= '0;
    end else if (load_i) begin
      run_q <= 1'b1;
      div_q <= div_i;
      pre_q <= '0;
      cnt_o <= '0;
    end else if (run_q && edge_i) begin
      if (pre_q == div_q - 1'b1) begin
        pre_q <= '0;
        cnt_o <= cnt_o + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_q |-> (cnt_o == '0)); // R1
  AST_LOAD_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> (cnt_o == '0 && pre_q == '0)); // R4
  AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
    run_q |-> (pre_q < div_q)); // R5
  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    !load_i |=> (cnt_o == $past(cnt_o) || cnt_o == CNT_W'($past(cnt_o) + 1'b1))); // R7
  AST_NO_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && !edge_i) |=> $stable(cnt_o)); // R5
  AST_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |-> (div_i != '0)); // R6
endmodule

// File: rtl/tick_cal_counter.sv
module tick_cal_counter
  import tick_pkg::*;
#(
  parameter int NUMER       = 256000,
  parameter int MEAS_W      = 16,
  parameter int PERIODS     = 16,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             slow_clk_i,
  input  logic             start_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] ticks_o,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             cal_err_o
);
  localparam int DVD_W = $clog2(NUMER + 2 ** (MEAS_W - 1) + 1);

  cal_state_e        state_q;
  logic              slow_rise;
  logic              meas_done;
  logic [MEAS_W-1:0] meas_val;
  logic              div_go_q;
  logic              div_done;
  logic [DVD_W-1:0]  quot;
  logic [DVD_W-1:0]  dividend;
  logic [DVD_W-1:0]  div_lat_q;
  logic              load_q;

  assign dividend = DVD_W'(NUMER) + DVD_W'(meas_val >> 1);

  tick_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .async_i(slow_clk_i), .rise_o(slow_rise));

  tick_period_meas #(.MEAS_W(MEAS_W), .PERIODS(PERIODS)) u_meas (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i), .edge_i(slow_rise),
    .done_o(meas_done), .value_o(meas_val));

  tick_seq_div #(.DVD_W(DVD_W), .DVS_W(MEAS_W)) u_div (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(div_go_q), .dividend_i(dividend),
    .divisor_i(meas_val), .done_o(div_done), .quot_o(quot));

  tick_prescaler #(.DIV_W(DVD_W), .CNT_W(CNT_W)) u_pre (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(load_q), .div_i(div_lat_q),
    .edge_i(slow_rise), .cnt_o(ticks_o));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q   <= CAL_IDLE;
      cal_err_o <= 1'b0;
      load_q    <= 1'b0;
      div_go_q  <= 1'b0;
      div_lat_q <= '0;
      rd_data_o <= '0;
    end else begin
      load_q   <= 1'b0;
      div_go_q <= 1'b0;
      if (rd_i) rd_data_o <= ticks_o;
      if (start_i) begin
        state_q <= CAL_MEAS;
      end else begin
        case (state_q)
          CAL_MEAS: if (meas_done) begin
            if (meas_val == '0) begin
              cal_err_o <= 1'b1;
              state_q   <= CAL_IDLE;
            end else begin
              div_go_q <= 1'b1;
              state_q  <= CAL_DIV;
            end
          end
          CAL_DIV: if (div_done) begin
            state_q <= CAL_IDLE;
            if (quot == '0) begin
              cal_err_o <= 1'b1;
            end else begin
              cal_err_o <= 1'b0;
              load_q    <= 1'b1;
              div_lat_q <= quot;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_ERR_ON_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == CAL_MEAS && meas_done && meas_val == '0 && !start_i) |=> cal_err_o); // R6
  AST_RD_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_i |=> (rd_data_o == $past(ticks_o))); // R8
  AST_LOAD_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    load_q |-> !cal_err_o); // R6
endmodule

// File: tb/tick_cal_counter_tb.sv
module tick_cal_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUMER      = 2560;
  localparam int MEAS_W     = 10;
  localparam int CNT_W      = 8;
  localparam int MODV       = 1 << CNT_W;
  localparam int WD_LIMIT   = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slow_clk = 1'b0;
  logic start = 1'b0;
  logic rd = 1'b0;
  logic [CNT_W-1:0] ticks;
  logic [CNT_W-1:0] rd_data;
  logic cal_err;

  int checks = 0;
  int errors = 0;
  int per_req = 20;
  int cur_per = 20;
  int ph = 0;
  int wd = 0;

  tick_cal_counter #(.NUMER(NUMER), .MEAS_W(MEAS_W), .PERIODS(16),
                     .CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_i(rst), .slow_clk_i(slow_clk), .start_i(start),
    .rd_i(rd), .ticks_o(ticks), .rd_data_o(rd_data), .cal_err_o(cal_err));

  always #(CLK_PERIOD / 2) clk = ~clk;

  // slow clock generated from the fast clock; a new period takes effect at a period boundary
  always @(negedge clk) begin
    if (ph == 0) cur_per = per_req;
    slow_clk = (ph < cur_per / 2);
    ph = (ph + 1 >= cur_per) ? 0 : ph + 1;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", wd, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_zero(input string req);
    int n;
    n = 0;
    while (ticks != '0 && n < 5000) begin @(negedge clk); n++; end
    check(ticks == '0, req, ticks, 0);
  endtask

  // behavioural model: after the next observed step, ticks advance every `spacing` cycles
  task automatic track(input int spacing, input int nt, input string tag);
    int prev, expv, since, snap, n;
    bit pend;
    prev = ticks; n = 0;
    while (ticks == prev && n < 20000) begin @(negedge clk); n++; end
    check(ticks != prev, {tag, " sync"}, ticks, (prev + 1) % MODV);
    expv = ticks; since = 0; pend = 1'b0; snap = 0;
    for (int t = 0; t < nt * spacing; t++) begin
      @(negedge clk);
      if (pend) begin
        check(rd_data == snap, "R8 read capture", rd_data, snap);
        rd = 1'b0; pend = 1'b0;
      end
      since++;
      if (since == spacing) begin expv = (expv + 1) % MODV; since = 0; end
      check(ticks == expv, tag, ticks, expv);
      if (t % 41 == 7) begin rd = 1'b1; snap = ticks; pend = 1'b1; end
    end
    @(negedge clk);
    if (pend) check(rd_data == snap, "R8 read capture", rd_data, snap);
    rd = 1'b0;
  endtask

  initial begin
    int v;
    cycles(4);
    check(ticks == '0 && rd_data == '0, "R1 reset outputs", ticks, 0);
    check(cal_err == 1'b0, "R1 reset error flag", cal_err, 0);
    rst = 1'b0;
    cycles(300);
    check(ticks == '0, "R1 idle before calibration", ticks, 0);

    // P=20: m=320, divider=(2560+160)/320=8, spacing 160; run past the 8-bit wrap
    pulse_start();
    track(160, 270, "R2 R3 R5 R7 tick spacing and wrap");
    check(cal_err == 1'b0, "R6 no error after good load", cal_err, 0);

    // P=25: m=400, divider=(2560+200)/400=6, spacing 150
    per_req = 25; cycles(200);
    pulse_start();
    wait_zero("R4 R9 load clears count");
    track(150, 20, "R9 recalibrated spacing");

    // P=64: 16*64=1024 wraps to m=0 in 10 bits -> rejected, divider 6 kept, spacing 384
    v = ticks;
    per_req = 64; cycles(200);
    v = ticks;
    pulse_start();
    cycles(1400);
    check(cal_err == 1'b1, "R6 zero measurement flagged", cal_err, 1);
    check(int'(ticks) >= v, "R6 count not cleared", ticks, v);
    track(384, 6, "R6 previous divider kept");

    // P=30: m=480, divider=(2560+240)/480=5, spacing 150
    per_req = 30; cycles(200);
    pulse_start();
    wait_zero("R4 load clears count");
    check(cal_err == 1'b0, "R6 error cleared by load", cal_err, 0);
    track(150, 10, "R3 R5 divider 5 spacing");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule